// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a bank of already-synchronised GPIO pin levels and turns selected pin activity into a single interrupt request. Each pin is configured separately. It can be level sensitive or edge sensitive, and it can be active high or active low. It can also be set to catch both transitions without software flipping its polarity after each event. Edge events are held in a per-pin latch until software acknowledges them. Level events follow the pin directly.

Software reaches the block through a small register port. Each write carries a register code, a half select and a 16-bit value with a 16-bit bit-enable. Only the enabled bits of the addressed half change, so two agents can update different pins without a read-modify-write. A read selector returns any configuration register, the raw status, the masked status or the pin levels. The interrupt output is the registered OR of the masked status.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, enable, type, polarity and both-edge registers read 0, the mask register reads all ones, raw status reads 0 and irqOut is 0.
- R2: A write sets `wrAddr[3:1]` to a register code: 0 enable, 1 mask, 2 type, 3 polarity, 4 both-edge, 5 acknowledge. Codes 6 and 7 have no effect. `wrAddr[0]=1` selects pins 31..16 and 0 selects pins 15..0. `wrData[15:0]` carries the values and `wrData[31:16]` the per-bit write enables, so only bits whose enable is 1 change. The new value is readable after the clock edge of the write.
- R3: A pin with type bit 0 is level sensitive. Its raw status bit equals its active level, which is high for polarity 1 and low for polarity 0, in the same cycle, and it is not latched.
- R4: A pin with type bit 1 and both-edge bit 0 latches a raw status bit on a rising edge when its polarity is 1 and on a falling edge when its polarity is 0. The opposite edge is ignored. The bit is readable after the clock edge that samples the new pin level.
- R5: A pin with both-edge bit 1 and type bit 1 latches on rising and on falling edges, whatever its polarity bit holds.
- R6: An acknowledge write clears the latched bit of each pin whose enable and value bits are both 1. A value of 0, or an enable of 0, leaves the latch set.
- R7: If an edge and its acknowledge fall in the same cycle, the latched bit stays set.
- R8: A mask bit of 1 removes the pin from the masked status and from irqOut, but its raw status still records the event.
- R9: A pin whose enable bit is 0 records nothing, and its raw status stays 0. Setting the enable later does not report an edge that occurred while it was disabled.
- R10: irqOut equals the OR of the masked status one clock edge earlier.
- R11: `rdSel` codes return 0 enable, 1 mask, 2 type, 3 polarity, 4 both-edge, 5 raw status, 6 masked status and 7 pin levels, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pins | input | 32 | Synchronised pin levels |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register code in bits 3..1, upper-half select in bit 0 |
| wrData | input | 32 | Bit enables in 31..16, values in 15..0 |
| rdSel | input | 3 | Read selector |
| rdData | output | 32 | Selected register or status |
| irqOut | output | 1 | Combined interrupt request |

## Verification
Configuration writes and latched edge status are due one clock edge after the stimulus. Level status is due in the same cycle, and irqOut one edge after the status that drives it, so an edge reaches irqOut two edges after the pin changes. The bench drives every input at the falling clock edge and reads one nanosecond later. It also checks irqOut both before and after its due edge to pin the one-cycle delay. Acknowledge and edge are applied in the same half cycle to exercise the case where both arrive together.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam logic [2:0] CODE_ENABLE = 3'd0;
  localparam logic [2:0] CODE_MASK   = 3'd1;
  localparam logic [2:0] CODE_TYPE   = 3'd2;
  localparam logic [2:0] CODE_POL    = 3'd3;
  localparam logic [2:0] CODE_BOTH   = 3'd4;
  localparam logic [2:0] CODE_ACK    = 3'd5;
  localparam logic [2:0] CODE_RAW    = 3'd5;
  localparam logic [2:0] CODE_MSTAT  = 3'd6;
  localparam logic [2:0] CODE_PINS   = 3'd7;

  typedef struct packed {
    logic upper;
    logic wrEnable;
    logic wrMask;
    logic wrType;
    logic wrPol;
    logic wrBoth;
    logic wrAck;
  } cfgStrobe_t;

endpackage

// File: rtl/irq_cfg_ctrl.sv
module irq_cfg_ctrl
  import gpio_irq_pkg::*;
(
  input  logic       wrEn,
  input  logic [3:0] wrAddr,
  output cfgStrobe_t strobe
);

  logic [2:0] code;
  assign code = wrAddr[3:1];

  always_comb begin
    strobe          = '0;
    strobe.upper    = wrAddr[0];
    strobe.wrEnable = wrEn && (code == CODE_ENABLE);
    strobe.wrMask   = wrEn && (code == CODE_MASK);
    strobe.wrType   = wrEn && (code == CODE_TYPE);
    strobe.wrPol    = wrEn && (code == CODE_POL);
    strobe.wrBoth   = wrEn && (code == CODE_BOTH);
    strobe.wrAck    = wrEn && (code == CODE_ACK);
  end

  // R2: a write reaches at most one register
  always_comb begin
    assert_single_target_R2: assert ($onehot0({strobe.wrEnable, strobe.wrMask, strobe.wrType,
                                              strobe.wrPol, strobe.wrBoth, strobe.wrAck}));
  end

endmodule

// File: rtl/irq_detect_dp.sv
module irq_detect_dp
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPINS-1:0] pins,
  input  cfgStrobe_t       strobe,
  input  logic [NPINS-1:0] wrData,
  input  logic [2:0]       rdSel,
  output logic [NPINS-1:0] rdData,
  output logic             irqOut
);

  localparam int unsigned HALF = NPINS / 2;

  logic [HALF-1:0]  bitVal, bitSel;
  logic [NPINS-1:0] fullEn, fullVal;

  assign bitVal = wrData[HALF-1:0];
  assign bitSel = wrData[NPINS-1:HALF];

  generate
    if (HALF * 2 == NPINS) begin : g_halves
      assign fullEn  = strobe.upper ? {bitSel, {HALF{1'b0}}} : {{HALF{1'b0}}, bitSel};
      assign fullVal = strobe.upper ? {bitVal, {HALF{1'b0}}} : {{HALF{1'b0}}, bitVal};
    end else begin : g_odd
      assign fullEn  = '0;
      assign fullVal = '0;
    end
  endgenerate

  function automatic logic [NPINS-1:0] mergeBits(input logic [NPINS-1:0] cur,
                                                 input logic [NPINS-1:0] en,
                                                 input logic [NPINS-1:0] val);
    return (cur & ~en) | (val & en);
  endfunction

  logic [NPINS-1:0] enReg, maskReg, typeReg, polReg, bothReg;
  logic [NPINS-1:0] prevPins, latchReg, latchNext;
  logic             primed, irqQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= '0;
      maskReg <= '1;
      typeReg <= '0;
      polReg  <= '0;
      bothReg <= '0;
    end else begin
      if (strobe.wrEnable) enReg   <= mergeBits(enReg, fullEn, fullVal);
      if (strobe.wrMask)   maskReg <= mergeBits(maskReg, fullEn, fullVal);
      if (strobe.wrType)   typeReg <= mergeBits(typeReg, fullEn, fullVal);
      if (strobe.wrPol)    polReg  <= mergeBits(polReg, fullEn, fullVal);
      if (strobe.wrBoth)   bothReg <= mergeBits(bothReg, fullEn, fullVal);
    end
  end

  logic [NPINS-1:0] ackVec, riseVec, fallVec, hitVec, edgeEvt, levelHit;
  logic [NPINS-1:0] rawStat, maskedStat;

  assign ackVec   = strobe.wrAck ? (fullEn & fullVal) : '0;
  assign riseVec  = pins & ~prevPins;
  assign fallVec  = ~pins & prevPins;
  assign hitVec   = (bothReg & (riseVec | fallVec)) |
                    (~bothReg & ((polReg & riseVec) | (~polReg & fallVec)));
  assign edgeEvt  = {NPINS{primed}} & enReg & typeReg & hitVec;
  assign latchNext = enReg & typeReg & (edgeEvt | (latchReg & ~ackVec));
  assign levelHit = enReg & ~typeReg & ~(pins ^ polReg);
  assign rawStat  = latchReg | levelHit;
  assign maskedStat = rawStat & ~maskReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevPins <= '0;
      primed   <= 1'b0;
      latchReg <= '0;
      irqQ     <= 1'b0;
    end else begin
      prevPins <= pins;
      primed   <= 1'b1;
      latchReg <= latchNext;
      irqQ     <= |maskedStat;
    end
  end

  assign irqOut = irqQ;

  always_comb begin
    unique case (rdSel)
      CODE_ENABLE: rdData = enReg;
      CODE_MASK:   rdData = maskReg;
      CODE_TYPE:   rdData = typeReg;
      CODE_POL:    rdData = polReg;
      CODE_BOTH:   rdData = bothReg;
      CODE_RAW:    rdData = rawStat;
      CODE_MSTAT:  rdData = maskedStat;
      default:     rdData = pins;
    endcase
  end

  // R6: an acknowledge without a coinciding edge clears the latch
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|(ackVec & ~edgeEvt)) |=> ((latchReg & $past(ackVec & ~edgeEvt)) == '0));

  // R7: an edge arriving with its acknowledge keeps the bit set
  assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|(edgeEvt & ackVec)) |=> ((latchReg & $past(edgeEvt & ackVec)) == $past(edgeEvt & ackVec)));

  // R9: no latched event on a pin disabled in the previous cycle
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((latchReg & ~$past(enReg)) == '0));

  // R10: output follows the masked status one cycle later
  assert_irq_delay_R10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|maskedStat)));

  // R4: a latched bit appears only through a detected edge
  assert_latch_source_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latchReg[0]) |-> $past(edgeEvt[0]));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPINS-1:0] pins,
  input  logic             wrEn,
  input  logic [3:0]       wrAddr,
  input  logic [NPINS-1:0] wrData,
  input  logic [2:0]       rdSel,
  output logic [NPINS-1:0] rdData,
  output logic             irqOut
);

  gpio_irq_pkg::cfgStrobe_t strobe;

  irq_cfg_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .strobe (strobe)
  );

  irq_detect_dp #(.NPINS(NPINS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .pins   (pins),
    .strobe (strobe),
    .wrData (wrData),
    .rdSel  (rdSel),
    .rdData (rdData),
    .irqOut (irqOut)
  );

endmodule

// File: tb/sim_gpio_irq_detect.sv
`timescale 1ns/1ps
module sim_gpio_irq_detect;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pinsV = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdSel = '0;
  logic [31:0] rdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_detect #(.NPINS(32)) u0 (
    .clk(clk), .rstN(rstN), .pins(pinsV), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .irqOut(irqOut)
  );

  localparam logic [2:0] S_EN = 0, S_MASK = 1, S_TYPE = 2, S_POL = 3, S_BOTH = 4,
                         S_ACK = 5, S_RAW = 5, S_MST = 6, S_PINS = 7;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkReg(input string req, input logic [2:0] s, input logic [31:0] exp);
    rdSel = s;
    #1;
    chk(req, rdData, exp);
  endtask

  task automatic chkIrq(input string req, input logic exp);
    #1;
    chk(req, {31'd0, irqOut}, {31'd0, exp});
  endtask

  task automatic wr(input logic [2:0] code, input logic hi, input logic [15:0] be,
                    input logic [15:0] val);
    wrEn = 1'b1;
    wrAddr = {code, hi};
    wrData = {be, val};
    tick();
    wrEn = 1'b0;
    wrData = '0;
  endtask

  task automatic testReset();
    chkReg("R1 enable", S_EN, 32'h0);
    chkReg("R1 mask", S_MASK, 32'hFFFF_FFFF);
    chkReg("R1 type", S_TYPE, 32'h0);
    chkReg("R1 raw", S_RAW, 32'h0);
    chkIrq("R1 irq", 1'b0);
  endtask

  task automatic testWrites();
    wr(S_TYPE, 0, 16'hFFFF, 16'hFFFF); wr(S_TYPE, 1, 16'hFFFF, 16'hFFFF);
    wr(S_POL, 0, 16'hFFFF, 16'hFFFF);  wr(S_POL, 1, 16'hFFFF, 16'hFFFF);
    wr(S_MASK, 0, 16'hFFFF, 16'h0000); wr(S_MASK, 1, 16'hFFFF, 16'h0000);
    wr(S_EN, 0, 16'hFFFF, 16'hFFFF);   wr(S_EN, 1, 16'hFFFF, 16'hFFFF);
    chkReg("R2 full enable", S_EN, 32'hFFFF_FFFF);
    chkReg("R11 polarity readback", S_POL, 32'hFFFF_FFFF);
    wr(S_EN, 0, 16'h00F0, 16'h0000);
    chkReg("R2 partial lower", S_EN, 32'hFFFF_FF0F);
    wr(S_EN, 0, 16'h00F0, 16'h00F0);
    chkReg("R2 restore", S_EN, 32'hFFFF_FFFF);
    wr(S_MASK, 1, 16'h0001, 16'h0001);
    chkReg("R2 upper half", S_MASK, 32'h0001_0000);
    wr(3'd6, 1, 16'hFFFF, 16'hFFFF);
    chkReg("R2 unused code", S_MASK, 32'h0001_0000);
    wr(S_MASK, 1, 16'h0001, 16'h0000);
    chkReg("R2 mask cleared", S_MASK, 32'h0);
  endtask

  task automatic testLevel();
    wr(S_TYPE, 0, 16'h0020, 16'h0000);
    pinsV[5] = 1'b1;
    chkReg("R3 active high same cycle", S_RAW, 32'h20);
    tick();
    chkIrq("R10 level irq", 1'b1);
    pinsV[5] = 1'b0;
    chkReg("R3 not latched", S_RAW, 32'h0);
    tick();
    chkIrq("R10 level irq drop", 1'b0);
    wr(S_POL, 0, 16'h0020, 16'h0000);
    chkReg("R3 active low", S_RAW, 32'h20);
    wr(S_POL, 0, 16'h0020, 16'h0020);
    wr(S_TYPE, 0, 16'h0020, 16'h0020);
    chkReg("R3 restored", S_RAW, 32'h0);
  endtask

  task automatic testEdge();
    pinsV[3] = 1'b1;
    tick();
    chkReg("R4 rising latched", S_RAW, 32'h8);
    chkIrq("R10 irq not yet", 1'b0);
    tick();
    chkIrq("R10 irq due", 1'b1);
    pinsV[3] = 1'b0;
    tick();
    chkReg("R4 latch held", S_RAW, 32'h8);
    wr(S_ACK, 0, 16'h0008, 16'h0000);
    chkReg("R6 ack value zero", S_RAW, 32'h8);
    wr(S_ACK, 0, 16'h0000, 16'h0008);
    chkReg("R6 ack not enabled", S_RAW, 32'h8);
    wr(S_ACK, 0, 16'h0008, 16'h0008);
    chkReg("R6 ack clears", S_RAW, 32'h0);
    tick();
    chkIrq("R10 irq cleared", 1'b0);
    wr(S_POL, 0, 16'h0010, 16'h0000);
    pinsV[4] = 1'b1;
    tick();
    chkReg("R4 rising ignored on falling pin", S_RAW, 32'h0);
    pinsV[4] = 1'b0;
    tick();
    chkReg("R4 falling latched", S_RAW, 32'h10);
    wr(S_ACK, 0, 16'h0010, 16'h0010);
    chkReg("R6 falling acked", S_RAW, 32'h0);
  endtask

  task automatic testBoth();
    wr(S_BOTH, 0, 16'h0040, 16'h0040);
    pinsV[6] = 1'b1;
    tick();
    chkReg("R5 rising", S_RAW, 32'h40);
    wr(S_ACK, 0, 16'h0040, 16'h0040);
    chkReg("R5 acked", S_RAW, 32'h0);
    pinsV[6] = 1'b0;
    tick();
    chkReg("R5 falling despite polarity 1", S_RAW, 32'h40);
    wr(S_ACK, 0, 16'h0040, 16'h0040);
    pinsV[6] = 1'b1;
    tick();
    chkReg("R5 rising again", S_RAW, 32'h40);
    pinsV[6] = 1'b0;
    wr(S_ACK, 0, 16'h0040, 16'h0040);
    chkReg("R7 edge wins over ack", S_RAW, 32'h40);
    wr(S_ACK, 0, 16'h0040, 16'h0040);
    chkReg("R7 later ack clears", S_RAW, 32'h0);
  endtask

  task automatic testMask();
    wr(S_MASK, 0, 16'h0008, 16'h0008);
    pinsV[3] = 1'b1;
    tick();
    chkReg("R8 raw records masked", S_RAW, 32'h8);
    chkReg("R8 masked status empty", S_MST, 32'h0);
    tick();
    chkIrq("R8 irq suppressed", 1'b0);
    wr(S_MASK, 0, 16'h0008, 16'h0000);
    chkReg("R8 unmasked status", S_MST, 32'h8);
    chkIrq("R10 irq after unmask not yet", 1'b0);
    tick();
    chkIrq("R10 irq after unmask", 1'b1);
    wr(S_ACK, 0, 16'h0008, 16'h0008);
    tick();
    chkIrq("R10 irq after ack", 1'b0);
  endtask

  task automatic testEnable();
    wr(S_EN, 0, 16'h0080, 16'h0000);
    pinsV[7] = 1'b1;
    tick();
    chkReg("R9 disabled no record", S_RAW, 32'h0);
    wr(S_EN, 0, 16'h0080, 16'h0080);
    chkReg("R9 enable no stale edge", S_RAW, 32'h0);
    tick();
    chkReg("R9 still clear", S_RAW, 32'h0);
  endtask

  task automatic testUpper();
    pinsV[20] = 1'b1;
    tick();
    chkReg("R4 upper pin rising", S_RAW, 32'h0010_0000);
    wr(S_ACK, 1, 16'h0010, 16'h0010);
    chkReg("R6 upper ack", S_RAW, 32'h0);
    chkReg("R11 pin levels", S_PINS, pinsV);
    chkReg("R11 both-edge readback", S_BOTH, 32'h40);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    testReset();
    testWrites();
    testLevel();
    testEdge();
    testBoth();
    testMask();
    testEnable();
    testUpper();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule